// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block paces all-bank refresh for a single DRAM rank. A free-running interval counter marks a refresh as due every `cfg_refi_i` clock cycles. When a refresh is due, the sequencer raises a hold signal so that the request scheduler stops starting new accesses. It then waits until every access already in flight has finished.

After the wait it closes any open rows with a precharge-all command and lets the row-precharge time pass. It then issues the refresh command and keeps the rank held for the refresh cycle time. When that time has passed it releases the hold.

The schedule of due points is fixed to a grid of multiples of the interval, counted from reset. It does not depend on when each refresh finished. A due point that arrives while a sequence is still running is remembered and served as soon as the sequencer is idle again. All three timing values are configuration inputs and must be at least 2.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, and on the first sample after it, `phase_o` is 0, `hold_req_o` is low, and both command strobes are low.
- R2: The first refresh becomes due exactly `cfg_refi_i` rising edges after reset is released. `phase_o` changes to 1 and `hold_req_o` rises on that edge, and both stay at their idle values on the edge before it.
- R3: In phase 1 the sequencer stays put for as long as `acc_busy_i` is high. It moves to phase 2 on the first edge at which `acc_busy_i` is seen low.
- R4: If `bank_open_i` is high in the first cycle of phase 2, `pre_all_o` is high for exactly that one cycle. Phase 3 begins `cfg_rp_i` cycles after that strobe cycle.
- R5: If `bank_open_i` is low in the first cycle of phase 2, no precharge-all strobe is given. Phase 3 begins in the very next cycle.
- R6: `refresh_o` is high for exactly one cycle, the first cycle of phase 3. Phase 0 returns, and `hold_req_o` falls, `cfg_rfc_i` cycles after the refresh strobe cycle.
- R7: `hold_req_o` is high in phases 1, 2 and 3 and low in phase 0. Every command strobe occurs while it is high.
- R8: Due points fall at whole multiples of `cfg_refi_i` after reset, whatever the completion times. A due point that arrives outside phase 0 is kept and moves the sequencer to phase 1 on the first edge after phase 0 is reached again.
- R9: `phase_o` encodes the phases as 0 = idle, 1 = draining, 2 = precharging, 3 = refreshing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_busy_i | input | 1 | High while any access to the rank is still outstanding |
| bank_open_i | input | 1 | High while at least one bank has an open row |
| cfg_refi_i | input | CFG_W | Refresh interval in cycles (at least 2) |
| cfg_rp_i | input | CFG_W | Row-precharge time in cycles (at least 2) |
| cfg_rfc_i | input | CFG_W | Refresh cycle time in cycles (at least 2) |
| hold_req_o | output | 1 | Stops new requests from being started |
| pre_all_o | output | 1 | One-cycle precharge-all command strobe |
| refresh_o | output | 1 | One-cycle refresh command strobe |
| phase_o | output | 2 | Current sequencer phase |

## Verification
The bench counts rising edges from reset release and samples on the falling edge, so each sample shows what the last edge registered. A due point shows at edge count k·`cfg_refi_i`, and leaving phase 1 shows one edge after `acc_busy_i` is dropped. The precharge-all strobe falls in the cycle that follows, and the refresh strobe comes `cfg_rp_i` cycles after the precharge-all strobe, or one cycle after entry into phase 2 when all banks are closed. The hold drops `cfg_rfc_i` cycles after the refresh strobe. Every check compares the outputs against edge numbers worked out from these offsets. The bench also checks the sample just before each expected change, so a transition that comes one cycle early or late is caught.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
// Shared types for the rank refresh sequencer.
// The phase values are visible on the top-level port, so the encoding is fixed.
package dram_refresh_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_PRECH = 2'd2,
        RS_RUN   = 2'd3
    } rstate_e;
endpackage

// File: rtl/ref_due_timer.sv
`timescale 1ns/1ps
// Refresh interval timer.
// Produces a due indication on a fixed grid of `interval` cycles after reset.
// A due point that the sequencer cannot take is held until the sequencer
// acknowledges it. Assumes interval >= 2.
module ref_due_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] interval,
    input  logic          ack,
    output logic          due_o
);
    logic [TW-1:0] cnt_q;
    logic          pend_q;
    logic          tick;

    // Grid point reached: the counter sits on its last value.
    assign tick  = (cnt_q >= (interval - TW'(1)));
    assign due_o = pend_q | tick;

    // Advance the interval counter; remember a due point until it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= tick ? '0 : cnt_q + TW'(1);
            pend_q <= (pend_q | tick) & ~ack;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && interval >= TW'(2)) |=> !tick);                  // R8
    AST_DUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (due_o && !ack) |=> due_o);                               // R8
endmodule

// File: rtl/ref_wait_timer.sv
`timescale 1ns/1ps
// Countdown timer for the precharge and refresh wait windows.
// Loaded with (window - 1) in the strobe cycle. It reports expiry in the last
// cycle of the window, so the next phase starts exactly `window` cycles after
// the strobe.
module ref_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q <= TW'(1));

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val > TW'(1)) |=> !expired);                // R4
endmodule

// File: rtl/ref_seq_fsm.sv
`timescale 1ns/1ps
// Refresh phase controller.
// Walks idle -> drain -> precharge -> refresh -> idle. It holds requests off
// outside idle, strobes each command for one cycle and arms the wait timer.
// The precharge wait is skipped when no bank is open. Assumes the wait timer
// reports expiry in the last cycle of a window.
module ref_seq_fsm
    import dram_refresh_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          due_i,
    input  logic          busy_i,
    input  logic          bank_open_i,
    input  logic          wait_exp_i,
    input  logic [TW-1:0] t_rp_i,
    input  logic [TW-1:0] t_rfc_i,
    output rstate_e       state_o,
    output logic          block_o,
    output logic          pre_all_o,
    output logic          ref_o,
    output logic          wait_load_o,
    output logic [TW-1:0] wait_val_o,
    output logic          due_ack_o
);
    rstate_e state_q, state_d;
    logic    issued_q;
    logic    strobe;

    // Command strobes: only in the first cycle of a phase.
    assign pre_all_o   = (state_q == RS_PRECH) && !issued_q && bank_open_i;
    assign ref_o       = (state_q == RS_RUN) && !issued_q;
    assign strobe      = pre_all_o | ref_o;
    assign wait_load_o = strobe;
    assign wait_val_o  = (state_q == RS_PRECH) ? (t_rp_i - TW'(1)) : (t_rfc_i - TW'(1));
    assign block_o     = (state_q != RS_IDLE);
    assign due_ack_o   = (state_q == RS_IDLE);
    assign state_o     = state_q;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (due_i)   state_d = RS_DRAIN;
            RS_DRAIN: if (!busy_i) state_d = RS_PRECH;
            RS_PRECH: if ((!issued_q && !bank_open_i) || (issued_q && wait_exp_i))
                          state_d = RS_RUN;
            RS_RUN:   if (issued_q && wait_exp_i) state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    // Phase register and per-phase "command already given" flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            issued_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            issued_q <= (state_d != state_q) ? 1'b0 : (issued_q | strobe);
        end
    end

    AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |=> !pre_all_o);                                // R4
    AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_o |=> !ref_o);                                        // R6
    AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_DRAIN && busy_i) |=> (state_q == RS_DRAIN)); // R3
    AST_RUN_OPENS_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_RUN && $past(state_q) != RS_RUN) |-> ref_o); // R6
    AST_CMD_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_o || ref_o) |-> block_o);                        // R7
endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
// Rank refresh sequencer, top level.
// Ties together the interval timer, the wait timer and the phase controller.
// All configuration values are in clock cycles and must be at least 2.
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_busy_i,
    input  logic             bank_open_i,
    input  logic [CFG_W-1:0] cfg_refi_i,
    input  logic [CFG_W-1:0] cfg_rp_i,
    input  logic [CFG_W-1:0] cfg_rfc_i,
    output logic             hold_req_o,
    output logic             pre_all_o,
    output logic             refresh_o,
    output logic [1:0]       phase_o
);
    logic             due;
    logic             due_ack;
    logic             wait_exp;
    logic             wait_load;
    logic [CFG_W-1:0] wait_val;
    rstate_e          phase;

    ref_due_timer #(.TW(CFG_W)) u_due (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (cfg_refi_i),
        .ack      (due_ack),
        .due_o    (due)
    );

    ref_wait_timer #(.TW(CFG_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .expired  (wait_exp)
    );

    ref_seq_fsm #(.TW(CFG_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .due_i       (due),
        .busy_i      (acc_busy_i),
        .bank_open_i (bank_open_i),
        .wait_exp_i  (wait_exp),
        .t_rp_i      (cfg_rp_i),
        .t_rfc_i     (cfg_rfc_i),
        .state_o     (phase),
        .block_o     (hold_req_o),
        .pre_all_o   (pre_all_o),
        .ref_o       (refresh_o),
        .wait_load_o (wait_load),
        .wait_val_o  (wait_val),
        .due_ack_o   (due_ack)
    );

    assign phase_o = phase;

    AST_HOLD_MATCHES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req_o == (phase_o != 2'd0));                         // R7
endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
    localparam int W     = 16;
    localparam int TREFI = 40;
    localparam int TRP   = 3;
    localparam int TRFC  = 6;

    // Vector: bit 8 = banks open during precharge phase, bits 7:0 = busy hold cycles
    localparam logic [8:0] VEC [4] = '{9'h100, 9'h005, 9'h102, 9'h000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b1;
    logic bopen = 1'b0;
    logic hold, pre, refr;
    logic [1:0] ph;
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    dram_refresh_seq #(.CFG_W(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_busy_i  (busy),
        .bank_open_i (bopen),
        .cfg_refi_i  (W'(TREFI)),
        .cfg_rp_i    (W'(TRP)),
        .cfg_rfc_i   (W'(TRFC)),
        .hold_req_o  (hold),
        .pre_all_o   (pre),
        .refresh_o   (refr),
        .phase_o     (ph)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic goto_edge(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // One full refresh sequence due at edge `due`.
    task automatic run_seq(input int due, input int holdc, input bit open);
        int r;
        goto_edge(due - 1);
        chk("R2 hold before due", int'(hold), 0);
        chk("R8 phase before due", int'(ph), 0);
        @(negedge clk);
        chk("R2 phase at due (R9 drain=1)", int'(ph), 1);
        chk("R7 hold at due", int'(hold), 1);
        bopen = open;
        repeat (holdc) @(negedge clk);
        chk("R3 still draining while busy", int'(ph), 1);
        busy = 1'b0;
        @(negedge clk);
        chk("R3 precharge phase (R9 value 2)", int'(ph), 2);
        chk("R7 hold in precharge", int'(hold), 1);
        chk(open ? "R4 precharge-all strobe" : "R5 no precharge-all", int'(pre), open ? 1 : 0);
        if (open) begin
            r = cyc + TRP;
            @(negedge clk);
            chk("R4 strobe one cycle", int'(pre), 0);
            goto_edge(r - 1);
            chk("R4 still precharging", int'(ph), 2);
            @(negedge clk);
        end else begin
            @(negedge clk);
            r = cyc;
        end
        chk(open ? "R4 refresh after tRP (R9 value 3)" : "R5 refresh next cycle", int'(ph), 3);
        chk("R6 refresh strobe", int'(refr), 1);
        @(negedge clk);
        chk("R6 refresh strobe one cycle", int'(refr), 0);
        goto_edge(r + TRFC - 1);
        chk("R6 still refreshing", int'(ph), 3);
        chk("R7 hold during refresh", int'(hold), 1);
        @(negedge clk);
        chk("R6 back to idle after tRFC", int'(ph), 0);
        chk("R7 hold released", int'(hold), 0);
        busy = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset phase", int'(ph), 0);
        chk("R1 reset hold", int'(hold), 0);
        chk("R1 reset strobes", int'(pre | refr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 phase after release", int'(ph), 0);
        chk("R1 hold after release", int'(hold), 0);

        for (int i = 0; i < 4; i++)
            run_seq((i + 1) * TREFI, int'(VEC[i][7:0]), VEC[i][8]);

        // Overrun: drain spans the next grid point at 240
        run_seq(5 * TREFI, 50, 1'b1);
        @(negedge clk);
        chk("R8 pending due taken after idle", int'(ph), 1);
        busy  = 1'b0;
        bopen = 1'b0;
        goto_edge(6 * TREFI + 35);
        chk("R8 idle before next grid point", int'(ph), 0);
        busy = 1'b1;
        run_seq(7 * TREFI, 0, 1'b1);

        // Reset in the middle of a drain
        goto_edge(8 * TREFI + 2);
        chk("R3 draining before reset", int'(ph), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears phase", int'(ph), 0);
        chk("R1 reset clears hold", int'(hold), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq(TREFI, 1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule